// File: doc/BRIEF.md
# Serial Flash Page-Program Engine

This block is the device-side command logic of a serial flash that accepts a page-program instruction over a four-wire serial link. It oversamples the serial clock, select and data inputs with the system clock. Input bits are taken on serial-clock rising edges while select is low. An 8-bit instruction, a 24-bit address and data bytes are assembled, and the data bytes are collected into a page buffer that wraps inside the addressed page.

When select returns high after a complete command, the engine checks the write-enable latch, the busy flag and a protected page range. It then merges the buffered bytes into a behavioural byte array and holds a busy flag for a parameterised number of system clocks. The array can only be cleared toward zero. A status instruction returns the busy and write-enable bits while the cycle runs. A combinational lookup port exposes the array contents.

Top module: `flash_pgm_engine`

## Requirements
- R1: A program command is the byte 0x02, then three address bytes (address bits 23..0, most significant bit first), then one or more data bytes. Each byte is sent most significant bit first and sampled on serial-clock rising edges while csn_i is low. It executes only when csn_i rises.
- R2: Data bytes are stored from the low address byte upward. A byte that passes offset 0xFF of the page continues at offset 0x00 of the same page.
- R3: When more than 256 data bytes are sent, each page offset receives the last byte sent to it, so only the final 256 bytes take effect.
- R4: Array bytes not addressed by the accepted data keep their previous values.
- R5: A program command executes only when the write-enable latch is set. The write-enable command is the single byte 0x06, and it sets the latch when csn_i rises. A program command sent with the latch clear changes nothing.
- R6: A program command whose page number (address bits 23..8) lies in [PROT_LO_PAGE, PROT_HI_PAGE] changes nothing and leaves the latch set.
- R7: After an accepted command, BUSY is 1 for max(PROG_CYCLES, PAGE_BYTES) clocks. Program and write-enable commands received while BUSY is set are ignored.
- R8: The status command is 0x05. Afterwards, miso_o shifts the status byte out most significant bit first, changing after serial-clock falling edges, and repeats it for as long as select stays low. BUSY is status bit 0, the write-enable latch is bit 1, and bits 7..2 are 0. miso_o is 0 while csn_i is high.
- R9: The write-enable latch is cleared when the program cycle ends.
- R10: Each programmed byte becomes the bitwise AND of its old value and the new data.
- R11: A command cut short by csn_i rising during the opcode or address bytes, or before the first full data byte, changes nothing.
- R12: After reset, BUSY and the latch are 0, every array byte is 0xFF, and miso_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock |
| csn_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out (status) |
| arr_addr_i | input | $clog2(MEM_BYTES) | Array lookup address |
| arr_data_o | output | 8 | Array byte at arr_addr_i |

## Verification
The assertions assume that serial inputs change slowly compared with the system clock. Each serial-clock level and each select level must last several clocks, so that the synchroniser reports every edge in order. They also assume that select never moves on the same clock as a serial-clock edge. The stimulus holds every serial-clock phase for six system clocks and keeps select steady for six clocks around each frame. Data changes only while the serial clock is low. The lookup port is read only while BUSY is 0, when the array is stable.

// File: rtl/flash_pgm_pkg.sv
package flash_pgm_pkg;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_DATA,
    PH_STAT,
    PH_WREN,
    PH_IGN
  } phase_e;
endpackage

// File: rtl/spi_front.sv
module spi_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic csn_i,
  input  logic mosi_i,
  output logic sel_o,
  output logic bit_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_fall_o,
  output logic cs_rise_o
);
  // lane order {sck, csn, mosi}
  localparam logic [2:0] IDLE = 3'b010;

  logic [2:0] stg_q [SYNC_STAGES+1];

  for (genvar g = 0; g <= SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= IDLE;
        else         stg_q[g] <= {sck_i, csn_i, mosi_i};
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= IDLE;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  logic [2:0] cur, prv;
  assign cur = stg_q[SYNC_STAGES-1];
  assign prv = stg_q[SYNC_STAGES];

  assign sel_o      = ~cur[1];
  assign bit_o      = cur[0];
  assign sck_rise_o = cur[2] & ~prv[2];
  assign sck_fall_o = ~cur[2] & prv[2];
  assign cs_fall_o  = ~cur[1] & prv[1];
  assign cs_rise_o  = cur[1] & ~prv[1];
endmodule

// File: rtl/cmd_rx.sv
module cmd_rx
  import flash_pgm_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  localparam int IDX_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             bit_i,
  input  logic             sck_rise_i,
  input  logic             sck_fall_i,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             busy_i,
  input  logic [7:0]       status_i,
  output logic             miso_o,
  output logic             buf_clr_o,
  output logic             buf_we_o,
  output logic [IDX_W-1:0] buf_idx_o,
  output logic [7:0]       buf_data_o,
  output logic [23:0]      addr_o,
  output logic             pp_req_o,
  output logic             wren_req_o
);
  phase_e           phase_q;
  logic [6:0]       sh_q;
  logic [2:0]       bit_idx_q;
  logic [1:0]       acnt_q;
  logic             data_seen_q;
  logic [IDX_W-1:0] ptr_q;
  logic [7:0]       sts_sh_q;
  logic [2:0]       out_cnt_q;
  logic [7:0]       rx_byte;

  assign rx_byte = {sh_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IGN;
      sh_q        <= '0;
      bit_idx_q   <= '0;
      acnt_q      <= '0;
      data_seen_q <= 1'b0;
      ptr_q       <= '0;
      sts_sh_q    <= '0;
      out_cnt_q   <= '0;
      miso_o      <= 1'b0;
      buf_clr_o   <= 1'b0;
      buf_we_o    <= 1'b0;
      buf_idx_o   <= '0;
      buf_data_o  <= '0;
      addr_o      <= '0;
      pp_req_o    <= 1'b0;
      wren_req_o  <= 1'b0;
    end else begin
      buf_clr_o  <= 1'b0;
      buf_we_o   <= 1'b0;
      pp_req_o   <= 1'b0;
      wren_req_o <= 1'b0;
      if (cs_fall_i) begin
        phase_q     <= PH_OPC;
        bit_idx_q   <= '0;
        acnt_q      <= '0;
        data_seen_q <= 1'b0;
        out_cnt_q   <= '0;
      end else if (cs_rise_i) begin
        pp_req_o   <= (phase_q == PH_DATA) && data_seen_q;
        wren_req_o <= (phase_q == PH_WREN);
        phase_q    <= PH_IGN;
        miso_o     <= 1'b0;
      end else if (sel_i && sck_rise_i) begin
        sh_q      <= rx_byte[6:0];
        bit_idx_q <= bit_idx_q + 3'd1;
        if (bit_idx_q == 3'd7) begin
          unique case (phase_q)
            PH_OPC: begin
              if (rx_byte == OP_PROG) begin
                if (busy_i) phase_q <= PH_IGN;
                else begin
                  phase_q   <= PH_ADDR;
                  buf_clr_o <= 1'b1;
                end
              end else if (rx_byte == OP_RDSR) begin
                phase_q   <= PH_STAT;
                sts_sh_q  <= status_i;
                out_cnt_q <= '0;
              end else if (rx_byte == OP_WREN) begin
                phase_q <= PH_WREN;
              end else begin
                phase_q <= PH_IGN;
              end
            end
            PH_ADDR: begin
              addr_o <= {addr_o[15:0], rx_byte};
              acnt_q <= acnt_q + 2'd1;
              if (acnt_q == 2'd2) begin
                phase_q <= PH_DATA;
                ptr_q   <= rx_byte[IDX_W-1:0];
              end
            end
            PH_DATA: begin
              buf_we_o    <= 1'b1;
              buf_idx_o   <= ptr_q;
              buf_data_o  <= rx_byte;
              ptr_q       <= ptr_q + 1'b1;
              data_seen_q <= 1'b1;
            end
            default: ;
          endcase
        end
      end else if (sel_i && sck_fall_i && phase_q == PH_STAT) begin
        miso_o    <= sts_sh_q[7];
        out_cnt_q <= out_cnt_q + 3'd1;
        if (out_cnt_q == 3'd7) sts_sh_q <= status_i;
        else                   sts_sh_q <= {sts_sh_q[6:0], 1'b0};
      end
    end
  end

  AST_MISO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> !miso_o); // R8
  AST_ONE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pp_req_o && wren_req_o)); // R1
endmodule

// File: rtl/page_buf.sv
module page_buf #(
  parameter int PAGE_BYTES = 256,
  localparam int IDX_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_data_o,
  output logic             rd_vld_o
);
  logic [7:0]            data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    vld_q <= '0;
    else if (clr_i) vld_q <= '0;
    else if (we_i)  vld_q[wr_idx_i] <= 1'b1;
  end

  // later bytes to the same offset overwrite earlier ones
  always_ff @(posedge clk_i) begin
    if (we_i) data_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = data_q[rd_idx_i];
  assign rd_vld_o  = vld_q[rd_idx_i];

  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (vld_q == '0)); // R4
endmodule

// File: rtl/prog_ctrl.sv
module prog_ctrl #(
  parameter int PAGE_BYTES   = 256,
  parameter int MEM_BYTES    = 1024,
  parameter int PROG_CYCLES  = 300,
  parameter int PROT_LO_PAGE = 3,
  parameter int PROT_HI_PAGE = 3,
  localparam int IDX_W    = $clog2(PAGE_BYTES),
  localparam int MEM_AW   = $clog2(MEM_BYTES),
  localparam int PG_W     = MEM_AW - IDX_W,
  localparam int PGN_W    = 24 - IDX_W,
  localparam int BUSY_LEN = (PROG_CYCLES < PAGE_BYTES) ? PAGE_BYTES : PROG_CYCLES,
  localparam int CNT_W    = $clog2(BUSY_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pp_req_i,
  input  logic              wren_req_i,
  input  logic [PGN_W-1:0]  page_num_i,
  input  logic [7:0]        buf_data_i,
  input  logic              buf_vld_i,
  output logic [IDX_W-1:0]  buf_idx_o,
  input  logic [MEM_AW-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o,
  output logic              wel_o
);
  logic [7:0]      mem_q [MEM_BYTES];
  logic [CNT_W-1:0] cnt_q;
  logic [PG_W-1:0]  page_q;
  logic             busy_q, wel_q;
  logic             prot, start, walk_we;
  logic [MEM_AW-1:0] wr_addr;

  assign prot = (page_num_i >= PGN_W'(PROT_LO_PAGE)) &&
                (page_num_i <= PGN_W'(PROT_HI_PAGE));
  assign start   = pp_req_i && wel_q && !busy_q && !prot;
  assign buf_idx_o = cnt_q[IDX_W-1:0];
  assign walk_we = busy_q && (cnt_q < CNT_W'(PAGE_BYTES)) && buf_vld_i;
  assign wr_addr = {page_q, cnt_q[IDX_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wel_q  <= 1'b0;
      cnt_q  <= '0;
      page_q <= '0;
    end else begin
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        page_q <= page_num_i[PG_W-1:0];
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(BUSY_LEN - 1)) begin
          busy_q <= 1'b0;
          wel_q  <= 1'b0;
        end
      end
      if (wren_req_i && !busy_q) wel_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'hFF;
    end else if (walk_we) begin
      mem_q[wr_addr] <= mem_q[wr_addr] & buf_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign busy_o    = busy_q;
  assign wel_o     = wel_q;

  AST_START_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> wel_q); // R5
  AST_START_UNPROT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !$past(prot)); // R6
  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q < CNT_W'(BUSY_LEN - 1)) |=> busy_q); // R7
  AST_WEL_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> !wel_q); // R9
  AST_ONLY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_we |=> ((mem_q[$past(wr_addr)] & ~$past(mem_q[wr_addr])) == 8'h00)); // R10
endmodule

// File: rtl/flash_pgm_engine.sv
module flash_pgm_engine #(
  parameter int PAGE_BYTES   = 256,
  parameter int MEM_BYTES    = 1024,
  parameter int PROG_CYCLES  = 300,
  parameter int PROT_LO_PAGE = 3,
  parameter int PROT_HI_PAGE = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         sck_i,
  input  logic                         csn_i,
  input  logic                         mosi_i,
  output logic                         miso_o,
  input  logic [$clog2(MEM_BYTES)-1:0] arr_addr_i,
  output logic [7:0]                   arr_data_o
);
  localparam int IDX_W = $clog2(PAGE_BYTES);

  logic sel, rx_bit, sck_rise, sck_fall, cs_fall, cs_rise;
  logic busy, wel;
  logic buf_clr, buf_we, buf_vld, pp_req, wren_req;
  logic [IDX_W-1:0] buf_wr_idx, buf_rd_idx;
  logic [7:0] buf_wr_data, buf_rd_data, status;
  logic [23:0] addr;

  assign status = {6'b0, wel, busy};

  spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i, .rst_ni, .sck_i, .csn_i, .mosi_i,
    .sel_o(sel), .bit_o(rx_bit), .sck_rise_o(sck_rise), .sck_fall_o(sck_fall),
    .cs_fall_o(cs_fall), .cs_rise_o(cs_rise)
  );

  cmd_rx #(.PAGE_BYTES(PAGE_BYTES)) u_rx (
    .clk_i, .rst_ni, .sel_i(sel), .bit_i(rx_bit),
    .sck_rise_i(sck_rise), .sck_fall_i(sck_fall),
    .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .busy_i(busy), .status_i(status), .miso_o,
    .buf_clr_o(buf_clr), .buf_we_o(buf_we), .buf_idx_o(buf_wr_idx),
    .buf_data_o(buf_wr_data), .addr_o(addr),
    .pp_req_o(pp_req), .wren_req_o(wren_req)
  );

  page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk_i, .rst_ni, .clr_i(buf_clr), .we_i(buf_we),
    .wr_idx_i(buf_wr_idx), .wr_data_i(buf_wr_data),
    .rd_idx_i(buf_rd_idx), .rd_data_o(buf_rd_data), .rd_vld_o(buf_vld)
  );

  prog_ctrl #(
    .PAGE_BYTES(PAGE_BYTES), .MEM_BYTES(MEM_BYTES), .PROG_CYCLES(PROG_CYCLES),
    .PROT_LO_PAGE(PROT_LO_PAGE), .PROT_HI_PAGE(PROT_HI_PAGE)
  ) u_prog (
    .clk_i, .rst_ni, .pp_req_i(pp_req), .wren_req_i(wren_req),
    .page_num_i(addr[23:IDX_W]),
    .buf_data_i(buf_rd_data), .buf_vld_i(buf_vld), .buf_idx_o(buf_rd_idx),
    .rd_addr_i(arr_addr_i), .rd_data_o(arr_data_o),
    .busy_o(busy), .wel_o(wel)
  );

  AST_BUF_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !(buf_we || buf_clr)); // R7
endmodule

// File: tb/flash_pgm_engine_tb.sv
module flash_pgm_engine_tb;
  localparam int MEM = 1024;
  localparam int PROG = 2000;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0, miso;
  logic [9:0] aa = '0;
  logic [7:0] ad;
  int checks = 0, fails = 0;
  logic [7:0] model [MEM];

  always #2.5 clk = ~clk;

  flash_pgm_engine #(.MEM_BYTES(MEM), .PROG_CYCLES(PROG)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .arr_addr_i(aa), .arr_data_o(ad)
  );

  localparam logic [23:0] V_ADDR [6] = '{24'h000010, 24'h0000F0, 24'h000100,
                                         24'h000220, 24'h000305, 24'h000012};
  localparam int          V_N    [6] = '{4, 32, 300, 3, 8, 4};
  localparam logic [7:0]  V_SEED [6] = '{8'h5A, 8'h33, 8'hC1, 8'h77, 8'h10, 8'hA5};
  localparam bit          V_WREN [6] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam bit          V_EXEC [6] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      clks(HALF);
      sck = 1'b1;
      rx[b] = miso;
      clks(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic cs_lo();
    csn = 1'b0;
    clks(HALF);
  endtask

  task automatic cs_hi();
    clks(HALF);
    csn = 1'b1;
    clks(HALF + 4);
  endtask

  task automatic wren();
    logic [7:0] r;
    cs_lo(); xfer(8'h06, r); cs_hi();
  endtask

  function automatic logic [7:0] dat(input logic [7:0] seed, input int i);
    return 8'(int'(seed) + i * 13);
  endfunction

  task automatic pp(input logic [23:0] a, input int n, input logic [7:0] seed);
    logic [7:0] r;
    cs_lo();
    xfer(8'h02, r);
    xfer(a[23:16], r); xfer(a[15:8], r); xfer(a[7:0], r);
    for (int i = 0; i < n; i++) xfer(dat(seed, i), r);
    cs_hi();
  endtask

  task automatic status(output logic [7:0] s);
    logic [7:0] r;
    cs_lo(); xfer(8'h05, r); xfer(8'h00, s); cs_hi();
  endtask

  // expected effect: last byte per page offset, ANDed into the array
  task automatic model_pp(input logic [23:0] a, input int n, input logic [7:0] seed);
    logic [7:0] img [256];
    bit         v   [256];
    for (int i = 0; i < 256; i++) v[i] = 1'b0;
    for (int i = 0; i < n; i++) begin
      img[(int'(a[7:0]) + i) % 256] = dat(seed, i);
      v[(int'(a[7:0]) + i) % 256]   = 1'b1;
    end
    for (int i = 0; i < 256; i++)
      if (v[i]) model[{a[9:8], 8'(i)}] &= img[i];
  endtask

  task automatic chk_array(input string tag);
    for (int i = 0; i < MEM; i++) begin
      aa = 10'(i);
      #1;
      chk(ad === model[i], tag, ad, model[i]);
    end
  endtask

  initial begin
    logic [7:0] s, s2, r;
    for (int i = 0; i < MEM; i++) model[i] = 8'hFF;
    clks(4);
    rst_n = 1'b1;
    clks(4);

    // reset state
    chk(miso === 1'b0, "R12 miso", miso, 0);
    status(s);
    chk(s === 8'h00, "R12 status", s, 8'h00);
    chk_array("R12 array");

    // table walk
    for (int v = 0; v < 6; v++) begin
      string tag;
      logic [7:0] e1, e2;
      case (v)
        0: tag = "R1 R4";
        1: tag = "R2";
        2: tag = "R3";
        3: tag = "R5";
        4: tag = "R6";
        default: tag = "R10";
      endcase
      if (V_WREN[v]) wren();
      pp(V_ADDR[v], V_N[v], V_SEED[v]);
      if (V_EXEC[v]) model_pp(V_ADDR[v], V_N[v], V_SEED[v]);
      e1 = V_EXEC[v] ? 8'h03 : (V_WREN[v] ? 8'h02 : 8'h00);
      e2 = V_EXEC[v] ? 8'h00 : e1;
      status(s);
      chk(s === e1, {tag, " R7 status in cycle"}, s, e1);
      clks(PROG + 50);
      status(s);
      chk(s === e2, {tag, " R9 status after cycle"}, s, e2);
      chk_array(tag);
    end

    // truncated commands
    wren();
    cs_lo(); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h00, r); cs_hi();
    cs_lo(); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h40, r); cs_hi();
    cs_lo(); xfer(8'h02, r); mosi = 1'b0; clks(HALF); sck = 1'b1; clks(HALF); sck = 1'b0; cs_hi();
    status(s);
    chk(s === 8'h02, "R11 status", s, 8'h02);
    chk_array("R11 array");

    // command during busy; status repeats in one frame
    pp(24'h000080, 2, 8'h0F);
    model_pp(24'h000080, 2, 8'h0F);
    pp(24'h000050, 2, 8'h00);
    cs_lo(); xfer(8'h05, r); xfer(8'h00, s); xfer(8'h00, s2); cs_hi();
    chk(s === 8'h03, "R8 first status byte", s, 8'h03);
    chk(s2 === 8'h03, "R8 repeated status byte", s2, 8'h03);
    clks(PROG + 50);
    status(s);
    chk(s === 8'h00, "R9 end", s, 8'h00);
    chk_array("R7 busy ignore");
    chk(miso === 1'b0, "R8 idle miso", miso, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule